// File: doc/BRIEF.md
# I2C Bus Event Trigger

This block watches the clock and data lines of an I2C bus without driving them. When a chosen bus event occurs, it raises a trigger pulse one system clock wide. Each line passes through a short synchronizer chain. Edge detection on the synchronized levels finds start and stop conditions and SCL transitions. A frame tracker counts the bits and bytes of each transfer. An event matcher compares the completed bytes against the selected trigger condition.

A three-bit mode input selects the condition:

| Value | Condition |
|---|---|
| 0 | Any start condition |
| 1 | Address and data match |
| 2 | Missing acknowledge |
| 3 | General call |
| 4 | Start byte or high-speed master code |

The address and data patterns are each given as a value and a care mask, so that any bit can be made a don't-care. A two-bit format input selects how the address is read from the bus: a plain 7-bit address, a 7-bit address followed by a sub-address byte, or a 10-bit address.

Top module: `i2c_evt_trig`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `trig_o` is low, and the block holds no partial byte or transfer state.
- R2: Mode 0 detects a start condition, which is SDA falling while SCL is high. If the changed SDA level is first captured at clk edge E, then `trig_o` is high for the single cycle that follows edge E+2. Repeated starts are detected in the same way.
- R3: A start condition or a stop condition (SDA rising while SCL is high) clears the bit and byte counts. A partial byte or a partial transfer before it has no effect on later matching.
- R4: A byte is nine SCL rising edges. The first eight carry data with the MSB first, and the ninth carries the acknowledge level (0 means acknowledged). The byte completes on the SCL falling edge that ends the ninth clock. All byte-based triggers fire on that edge, with the same three-cycle latency as R2.
- R5: Mode 1 with format 0 works as follows. Bits 7:1 of the first byte are compared with `addr_val[6:0]` and bit 0 (R/W) is ignored. The second byte is the data byte and is compared with `data_val`. The trigger fires when the data byte completes, and only if both comparisons match. It fires at most once per transfer.
- R6: A pattern bit whose care bit is 0 matches either bus level. This applies to address, sub-address and data.
- R7: Format 1 compares the second byte with `sub_val`/`sub_care`. The data byte is then the third byte.
- R8: Format 2 requires the first byte to be `11110` in bits 7:3. Address bits 9:8 come from first-byte bits 2:1 and address bits 7:0 come from the second byte. The third byte is the data byte.
- R9: Mode 2 fires when any byte completes with its acknowledge level high.
- R10: Mode 3 fires when the first byte of a transfer completes with the value 0x00.
- R11: Mode 4 fires when the first byte of a transfer completes with the value 0x01, or with any value of the form `00001xxx`.
- R12: Mode values 5 to 7 never fire, and format value 3 never fires in mode 1.
- R13: Every trigger is exactly one clk cycle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| mode_sel | input | 3 | Trigger condition select (see R2, R5, R9-R12) |
| fmt_sel | input | 2 | Address format for mode 1 (0: 7-bit, 1: 7-bit plus sub-address, 2: 10-bit) |
| addr_val | input | 10 | Address pattern value |
| addr_care | input | 10 | Address care mask (1 = compare) |
| sub_val | input | 8 | Sub-address pattern value |
| sub_care | input | 8 | Sub-address care mask |
| data_val | input | 8 | Data pattern value |
| data_care | input | 8 | Data care mask |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is steady, and each line level lasts longer than the synchronizer depth. The configuration inputs stay steady while a transfer is in progress. The stimulus holds every SCL and SDA level for four clocks, and never moves both lines in the same cycle. It changes the mode, format and patterns only while the bus is idle after a stop.

// File: rtl/i2c_trig_pkg.sv
package i2c_trig_pkg;

    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 2;
    localparam int BITS_PER_SLOT = BYTE_W + 1;
    localparam int CNT_W  = $clog2(BITS_PER_SLOT + 1);

    typedef enum logic [2:0] {
        TM_START     = 3'd0,
        TM_ADDR_DATA = 3'd1,
        TM_NACK      = 3'd2,
        TM_GCALL     = 3'd3,
        TM_PREAMBLE  = 3'd4
    } trig_mode_e;

    typedef enum logic [1:0] {
        AF_SEVEN     = 2'd0,
        AF_SEVEN_SUB = 2'd1,
        AF_TEN       = 2'd2,
        AF_RSVD      = 2'd3
    } addr_fmt_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic              done;
        logic [BYTE_W-1:0] value;
        logic              ack_n;
        logic [IDX_W-1:0]  idx;
    } byte_evt_t;

    function automatic logic bits_match(input logic [ADDR_W-1:0] got,
                                        input logic [ADDR_W-1:0] want,
                                        input logic [ADDR_W-1:0] care);
        return ((got ^ want) & care) == '0;
    endfunction

    function automatic logic is_preamble(input logic [BYTE_W-1:0] b);
        return (b == 8'h01) || (b[7:3] == 5'b00001);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_trig_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt,
    output logic     sda_lvl
);

    logic [STAGES-1:0] scl_p, sda_p;
    logic [STAGES-1:0] scl_nx, sda_nx;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    generate
        if (STAGES == 1) begin : g_one
            assign scl_nx = scl_in;
            assign sda_nx = sda_in;
        end else begin : g_chain
            assign scl_nx = {scl_p[STAGES-2:0], scl_in};
            assign sda_nx = {sda_p[STAGES-2:0], sda_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= scl_nx;
            sda_p <= sda_nx;
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & ~sda_s & sda_q;
        evt.stop     = scl_s & scl_q & sda_s & ~sda_q;
    end

    assign sda_lvl = sda_s;

endmodule

// File: rtl/i2c_frame_track.sv
module i2c_frame_track
    import i2c_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_evt_t  evt,
    input  logic      sda_lvl,
    output byte_evt_t bev
);

    logic              active;
    logic [CNT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  byte_idx;
    logic [BYTE_W-1:0] shreg;
    logic              ack_n;
    logic              slot_end;

    assign slot_end = active && evt.scl_fall && !evt.start && !evt.stop
                      && (bit_cnt == CNT_W'(BITS_PER_SLOT));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            ack_n    <= 1'b0;
        end else if (evt.start) begin
            active   <= 1'b1;
            bit_cnt  <= '0;
            byte_idx <= '0;
        end else if (evt.stop) begin
            active   <= 1'b0;
            bit_cnt  <= '0;
            byte_idx <= '0;
        end else if (active) begin
            if (evt.scl_rise && bit_cnt < CNT_W'(BITS_PER_SLOT)) begin
                if (bit_cnt < CNT_W'(BYTE_W))
                    shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                else
                    ack_n <= sda_lvl;
                bit_cnt <= bit_cnt + 1'b1;
            end else if (slot_end) begin
                bit_cnt <= '0;
                if (byte_idx != '1)
                    byte_idx <= byte_idx + 1'b1;
            end
        end
    end

    always_comb begin
        bev.done  = slot_end;
        bev.value = shreg;
        bev.ack_n = ack_n;
        bev.idx   = byte_idx;
    end

    a_r4_bit_count_bounded: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(BITS_PER_SLOT));

    a_r3_start_clears_counts: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (bit_cnt == '0 && byte_idx == '0));

    a_r3_stop_clears_counts: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !evt.start) |=> (bit_cnt == '0 && byte_idx == '0 && !bev.done));

endmodule

// File: rtl/i2c_evt_match.sv
module i2c_evt_match
    import i2c_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  byte_evt_t         bev,
    input  logic [2:0]        mode_sel,
    input  logic [1:0]        fmt_sel,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [ADDR_W-1:0] addr_care,
    input  logic [BYTE_W-1:0] sub_val,
    input  logic [BYTE_W-1:0] sub_care,
    input  logic [BYTE_W-1:0] data_val,
    input  logic [BYTE_W-1:0] data_care,
    output logic              trig_o
);

    localparam int PAD7 = ADDR_W - 7;
    localparam int PAD8 = ADDR_W - BYTE_W;
    localparam int PAD2 = ADDR_W - 2;

    trig_mode_e       mode;
    addr_fmt_e        fmt;
    logic             lo7_ok, ten_hi_ok, ten_lo_ok, sub_ok, data_ok, first_ok;
    logic             hdr_ok;
    logic [IDX_W-1:0] data_slot;
    logic             addr_hit;
    logic             trig_d;

    assign mode = trig_mode_e'(mode_sel);
    assign fmt  = addr_fmt_e'(fmt_sel);

    always_comb begin
        lo7_ok    = bits_match({{PAD7{1'b0}}, bev.value[7:1]},
                               {{PAD7{1'b0}}, addr_val[6:0]},
                               {{PAD7{1'b0}}, addr_care[6:0]});
        ten_hi_ok = (bev.value[7:3] == 5'b11110) &&
                    bits_match({{PAD2{1'b0}}, bev.value[2:1]},
                               {{PAD2{1'b0}}, addr_val[9:8]},
                               {{PAD2{1'b0}}, addr_care[9:8]});
        ten_lo_ok = bits_match({{PAD8{1'b0}}, bev.value},
                               {{PAD8{1'b0}}, addr_val[7:0]},
                               {{PAD8{1'b0}}, addr_care[7:0]});
        sub_ok    = bits_match({{PAD8{1'b0}}, bev.value},
                               {{PAD8{1'b0}}, sub_val},
                               {{PAD8{1'b0}}, sub_care});
        data_ok   = bits_match({{PAD8{1'b0}}, bev.value},
                               {{PAD8{1'b0}}, data_val},
                               {{PAD8{1'b0}}, data_care});
        case (fmt)
            AF_SEVEN, AF_SEVEN_SUB: first_ok = lo7_ok;
            AF_TEN:                 first_ok = ten_hi_ok;
            default:                first_ok = 1'b0;
        endcase
        data_slot = (fmt == AF_SEVEN) ? IDX_W'(1) : IDX_W'(2);
        addr_hit  = bev.done && (fmt != AF_RSVD) && (bev.idx == data_slot)
                    && hdr_ok && data_ok;
    end

    always_ff @(posedge clk) begin
        if (rst || evt.start || evt.stop) begin
            hdr_ok <= 1'b0;
        end else if (bev.done) begin
            if (bev.idx == '0)
                hdr_ok <= first_ok;
            else if (bev.idx == IDX_W'(1) && fmt == AF_SEVEN_SUB)
                hdr_ok <= hdr_ok & sub_ok;
            else if (bev.idx == IDX_W'(1) && fmt == AF_TEN)
                hdr_ok <= hdr_ok & ten_lo_ok;
        end
    end

    always_comb begin
        case (mode)
            TM_START:     trig_d = evt.start;
            TM_ADDR_DATA: trig_d = addr_hit;
            TM_NACK:      trig_d = bev.done && bev.ack_n;
            TM_GCALL:     trig_d = bev.done && bev.idx == '0 && bev.value == '0;
            TM_PREAMBLE:  trig_d = bev.done && bev.idx == '0 && is_preamble(bev.value);
            default:      trig_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) trig_o <= 1'b0;
        else     trig_o <= trig_d;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !trig_o);

    a_r13_single_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    a_r12_reserved_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> ($past(mode_sel) <= 3'd4));

    a_r9_nack_needs_high_ack: assert property (@(posedge clk) disable iff (rst)
        (trig_o && $past(mode_sel) == 3'd2) |-> $past(bev.ack_n));

    a_r5_addr_hit_needs_header: assert property (@(posedge clk) disable iff (rst)
        (trig_o && $past(mode_sel) == 3'd1) |-> $past(hdr_ok));

endmodule

// File: rtl/i2c_evt_trig.sv
module i2c_evt_trig
    import i2c_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        mode_sel,
    input  logic [1:0]        fmt_sel,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [ADDR_W-1:0] addr_care,
    input  logic [BYTE_W-1:0] sub_val,
    input  logic [BYTE_W-1:0] sub_care,
    input  logic [BYTE_W-1:0] data_val,
    input  logic [BYTE_W-1:0] data_care,
    output logic              trig_o
);

    bus_evt_t  evt;
    byte_evt_t bev;
    logic      sda_lvl;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .evt     (evt),
        .sda_lvl (sda_lvl)
    );

    i2c_frame_track u_track (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .sda_lvl (sda_lvl),
        .bev     (bev)
    );

    i2c_evt_match u_match (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .bev       (bev),
        .mode_sel  (mode_sel),
        .fmt_sel   (fmt_sel),
        .addr_val  (addr_val),
        .addr_care (addr_care),
        .sub_val   (sub_val),
        .sub_care  (sub_care),
        .data_val  (data_val),
        .data_care (data_care),
        .trig_o    (trig_o)
    );

endmodule

// File: tb/i2c_evt_trig_tb_top.sv
`timescale 1ns/1ps
module i2c_evt_trig_tb_top;

    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] mode_sel = 3'd0;
    logic [1:0] fmt_sel = 2'd0;
    logic [9:0] addr_val = '0, addr_care = '0;
    logic [7:0] sub_val = '0, sub_care = '0, data_val = '0, data_care = '0;
    logic       trig_o;

    int vectors = 0;
    int fails   = 0;
    int pcount  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    i2c_evt_trig dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_drv),
        .mode_sel(mode_sel), .fmt_sel(fmt_sel),
        .addr_val(addr_val), .addr_care(addr_care),
        .sub_val(sub_val), .sub_care(sub_care),
        .data_val(data_val), .data_care(data_care),
        .trig_o(trig_o)
    );

    // ---------------- behavioural reference model ----------------
    int  m_ps = 1, m_pd = 1, m_bits = 0, m_sh = 0, m_ack = 0;
    bit  m_act = 0;
    int  m_bytes[$];
    bit  e1 = 0, e2 = 0, e3 = 0;

    function automatic bit meq(int a, int b, int care);
        return ((a ^ b) & care) == 0;
    endfunction

    function automatic bit byte_fires();
        int n = m_bytes.size();
        case (mode_sel)
            3'd1: begin
                if (fmt_sel == 2'd0)
                    return n == 2 && meq(m_bytes[0] >> 1, addr_val & 10'h7F, addr_care & 10'h7F)
                           && meq(m_bytes[1], data_val, data_care);
                if (fmt_sel == 2'd1)
                    return n == 3 && meq(m_bytes[0] >> 1, addr_val & 10'h7F, addr_care & 10'h7F)
                           && meq(m_bytes[1], sub_val, sub_care)
                           && meq(m_bytes[2], data_val, data_care);
                if (fmt_sel == 2'd2)
                    return n == 3 && (m_bytes[0] >> 3) == 'h1E
                           && meq((((m_bytes[0] >> 1) & 3) << 8) | m_bytes[1], addr_val, addr_care)
                           && meq(m_bytes[2], data_val, data_care);
                return 0;
            end
            3'd2: return m_ack != 0;
            3'd3: return n == 1 && m_bytes[0] == 0;
            3'd4: return n == 1 && (m_bytes[0] == 1 || (m_bytes[0] >> 3) == 1);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit ev;
        int s, d;
        ev = 0;
        if (rst) begin
            m_ps = 1; m_pd = 1; m_bits = 0; m_act = 0; m_bytes.delete();
        end else begin
            s = int'(scl_drv); d = int'(sda_drv);
            if (s && m_ps && !d && m_pd) begin
                ev = (mode_sel == 3'd0);
                m_act = 1; m_bits = 0; m_bytes.delete();
            end else if (s && m_ps && d && !m_pd) begin
                m_act = 0; m_bits = 0; m_bytes.delete();
            end else if (m_act && s && !m_ps && m_bits < 9) begin
                if (m_bits < 8) m_sh = ((m_sh << 1) | d) & 255;
                else            m_ack = d;
                m_bits++;
            end else if (m_act && !s && m_ps && m_bits == 9) begin
                m_bits = 0;
                m_bytes.push_back(m_sh);
                ev = byte_fires();
            end
            m_ps = s; m_pd = d;
        end
        e3 <= rst ? 1'b0 : e2;
        e2 <= rst ? 1'b0 : e1;
        e1 <= rst ? 1'b0 : ev;
    end

    function automatic string mode_tag();
        case (mode_sel)
            3'd0: return "R2";
            3'd1: return "R5";
            3'd2: return "R9";
            3'd3: return "R10";
            3'd4: return "R11";
            default: return "R12";
        endcase
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            vectors++;
            if (trig_o !== e3) begin
                fails++;
                $display("FAIL %s/R13 cycle %0d: trig_o=%b expected=%b",
                         mode_tag(), cycles, trig_o, e3);
            end
            if (trig_o === 1'b1) pcount++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b0; wait_cyc(H);
        scl_drv = 1'b0; wait_cyc(H);
    endtask

    task automatic bus_restart();
        sda_drv = 1'b1; wait_cyc(H);
        scl_drv = 1'b1; wait_cyc(H);
        sda_drv = 1'b0; wait_cyc(H);
        scl_drv = 1'b0; wait_cyc(H);
    endtask

    task automatic put_bit(bit b);
        sda_drv = b;    wait_cyc(H);
        scl_drv = 1'b1; wait_cyc(H);
        scl_drv = 1'b0; wait_cyc(H);
    endtask

    task automatic put_byte(logic [7:0] b, bit ack_n);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        put_bit(ack_n);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_cyc(H);
        scl_drv = 1'b1; wait_cyc(H);
        sda_drv = 1'b1; wait_cyc(3 * H);
    endtask

    task automatic xfer3(logic [7:0] a, logic [7:0] b, logic [7:0] c);
        bus_start(); put_byte(a, 0); put_byte(b, 0); put_byte(c, 0); bus_stop();
    endtask

    task automatic expect_pulses(string tag, int exp);
        wait_cyc(6);
        check(tag, pcount, exp);
        pcount = 0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        while (cycles < 150000 && !done) @(negedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=finished", cycles);
            done = 1'b1;
            report();
        end
    end

    initial begin
        wait_cyc(5);
        check("R1 trig during reset", int'(trig_o), 0);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 trig after reset", int'(trig_o), 0);
        wait_cyc(4);
        pcount = 0;

        // R2: start latency and R13 pulse width
        mode_sel = 3'd0;
        sda_drv = 1'b0;
        wait_cyc(1); check("R2 latency n1", int'(trig_o), 0);
        wait_cyc(1); check("R2 latency n2", int'(trig_o), 0);
        wait_cyc(1); check("R2 latency n3", int'(trig_o), 1);
        wait_cyc(1); check("R13 width", int'(trig_o), 0);
        wait_cyc(H);
        scl_drv = 1'b0; wait_cyc(H);
        put_byte(8'hA0, 0);
        bus_restart();
        put_byte(8'hA1, 0);
        bus_stop();
        expect_pulses("R2 start and repeated start", 2);

        // R5 seven-bit address plus data
        mode_sel = 3'd1; fmt_sel = 2'd0;
        addr_val = 10'h050; addr_care = 10'h07F;
        data_val = 8'h3C; data_care = 8'hFF;
        xfer3(8'hA0, 8'h3C, 8'h3C);
        expect_pulses("R5 match once", 1);
        xfer3(8'hA1, 8'h3D, 8'h3C);
        expect_pulses("R5 data mismatch", 0);
        xfer3(8'hA2, 8'h3C, 8'h3C);
        expect_pulses("R5 address mismatch", 0);

        // R6 don't-care bits
        data_care = 8'hF0;
        xfer3(8'hA0, 8'h3D, 8'h00);
        expect_pulses("R6 data care mask", 1);
        addr_care = 10'h07C; data_care = 8'hFF;
        xfer3(8'hA6, 8'h3C, 8'h00);
        expect_pulses("R6 address care mask", 1);
        addr_care = 10'h07F;

        // R3 stop and repeated start clear counts
        bus_start(); put_bit(1); put_bit(0); put_bit(1); bus_stop();
        xfer3(8'hA0, 8'h3C, 8'h00);
        expect_pulses("R3 stop after partial byte", 1);
        bus_start(); put_byte(8'h77, 0); bus_restart();
        put_byte(8'hA0, 0); put_byte(8'h3C, 0); bus_stop();
        expect_pulses("R3 repeated start", 1);

        // R7 sub-address format
        fmt_sel = 2'd1; sub_val = 8'h12; sub_care = 8'hFF;
        xfer3(8'hA0, 8'h12, 8'h3C);
        expect_pulses("R7 sub match", 1);
        xfer3(8'hA0, 8'h13, 8'h3C);
        expect_pulses("R7 sub mismatch", 0);

        // R8 ten-bit format, address 0x2A5
        fmt_sel = 2'd2; addr_val = 10'h2A5; addr_care = 10'h3FF;
        xfer3(8'hF4, 8'hA5, 8'h3C);
        expect_pulses("R8 ten-bit match", 1);
        xfer3(8'hF4, 8'hA4, 8'h3C);
        expect_pulses("R8 low byte mismatch", 0);
        xfer3(8'hE4, 8'hA5, 8'h3C);
        expect_pulses("R8 prefix mismatch", 0);

        // R12 reserved format
        fmt_sel = 2'd3;
        xfer3(8'hF4, 8'hA5, 8'h3C);
        expect_pulses("R12 reserved format", 0);

        // R9 missing acknowledge, R4 framing
        mode_sel = 3'd2; fmt_sel = 2'd0;
        bus_start(); put_byte(8'hA0, 0); put_byte(8'h3C, 1); bus_stop();
        expect_pulses("R9 R4 nack on second byte", 1);
        xfer3(8'hFF, 8'hFF, 8'hFF);
        expect_pulses("R9 all acknowledged", 0);

        // R10 general call
        mode_sel = 3'd3;
        xfer3(8'h00, 8'h00, 8'h00);
        expect_pulses("R10 R4 general call first byte only", 1);
        xfer3(8'h02, 8'h00, 8'h00);
        expect_pulses("R10 non-zero first byte", 0);

        // R11 start byte and high-speed code
        mode_sel = 3'd4;
        xfer3(8'h01, 8'h01, 8'h00);
        expect_pulses("R11 start byte", 1);
        xfer3(8'h0D, 8'h00, 8'h00);
        expect_pulses("R11 high-speed code", 1);
        xfer3(8'h11, 8'h01, 8'h00);
        expect_pulses("R11 other byte", 0);

        // R12 reserved modes
        mode_sel = 3'd6;
        bus_start(); put_byte(8'h00, 1); bus_stop();
        expect_pulses("R12 reserved mode", 0);

        wait_cyc(10);
        done = 1'b1;
        report();
    end

endmodule